// File: doc/BRIEF.md
# Digit-Addressed Scratchpad Memory Unit

This block is the working-storage unit of a small 4-bit controller. It holds 512 bits as 8 rows of 16 four-bit digits. A 7-bit pointer picks one digit: its upper 3 bits name the row and its lower 4 bits name the digit within that row. Each cycle, one transfer moves a digit between the selected memory location and one of four places: the accumulator, an input port, an output latch or a small counter. The exchange with the accumulator happens in a single step.

A sequencer drives the block with a vector of operation selects, one bit per transfer. For a single access, an immediate address can stand in for the pointer, or the same immediate value can be copied into the pointer. The pointer's 4-bit digit field is also driven onto a parallel output at all times. The digit at the pointer is always visible on a read port, so the surrounding logic can observe memory without a transfer.

Top module: `digit_ram_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the pointer, accumulator, latch and counter are all cleared to zero after that edge. Memory contents are not defined by reset.
- R2: The addressed location is row = address[6:4] and digit = address[3:0]. `rd_digit` always shows the digit stored at the location named by `ptr_q`.
- R3: `op_req` equal to 8'h01 (bit 0 only) writes the accumulator into the addressed digit at the clock edge.
- R4: `op_req` equal to 8'h02 (bit 1 only) loads the addressed digit into the accumulator.
- R5: `op_req` equal to 8'h04 (bit 2 only) exchanges the two values at one edge. The memory receives the old accumulator and the accumulator receives the old memory digit.
- R6: `op_req` equal to 8'h08 (bit 3 only) writes `port_in` into the addressed digit.
- R7: `op_req` equal to 8'h10 (bit 4 only) copies the addressed digit into the latch. 8'h20 (bit 5 only) writes the latch into the addressed digit.
- R8: `op_req` equal to 8'h40 (bit 6 only) loads the counter from the addressed digit. 8'h80 (bit 7 only) writes the counter into the addressed digit. When the counter is not being loaded, `cnt_tick` adds one to it, and the count wraps from 15 to 0.
- R9: With `imm_sel` high, the access uses `imm_addr` in place of the pointer, and the pointer is left unchanged.
- R10: With `ptr_load` high, the pointer takes `imm_addr` at the edge. An access in that same cycle still uses the old address, unless `imm_sel` is also high.
- R11: `dig_out` always equals the low 4 bits of the pointer.
- R12: If more than one bit of `op_req` is set, no transfer is made. Memory, accumulator, latch and counter are left as they were, apart from `acc_ld_en` and `cnt_tick`.
- R13: `acc_ld_en` loads `acc_ld_val` into the accumulator. If R4 or R5 is in effect in the same cycle, the memory transfer takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_req | input | 8 | Operation selects, one bit per transfer |
| imm_addr | input | 7 | Immediate address operand |
| imm_sel | input | 1 | Use `imm_addr` for this access |
| ptr_load | input | 1 | Copy `imm_addr` into the pointer |
| port_in | input | 4 | Input port value |
| acc_ld_en | input | 1 | Load accumulator from `acc_ld_val` |
| acc_ld_val | input | 4 | Accumulator value from outside |
| cnt_tick | input | 1 | Counter increment |
| acc_q | output | 4 | Accumulator |
| latch_q | output | 4 | Output latch |
| cnt_q | output | 4 | Counter |
| ptr_q | output | 7 | Pointer |
| dig_out | output | 4 | Digit field of the pointer |
| rd_digit | output | 4 | Memory digit at the pointer |

## Verification
The memory-transfer properties assume that `imm_sel` and, where the memory side is observed after the edge, `ptr_load` are low in the cycle of the operation. Under those conditions the location read through `rd_digit` before and after the edge is the same location that was accessed. The no-op property further assumes that neither `acc_ld_en` nor `cnt_tick` is active. Random stimulus breaks these conditions freely: the antecedents only select the cycles where they hold, while the bench model covers every combination. Memory is filled through immediate-addressed port writes before any read, so no check ever depends on undefined contents.

// File: rtl/dram_pkg.sv
// Shared definitions for the digit-addressed scratchpad memory unit.
// Assumes the operation-select vector carries one bit per transfer kind.
package dram_pkg;
    localparam int N_OPS = 8;

    typedef enum logic [3:0] {
        OP_NONE    = 4'd0,
        OP_ST_ACC  = 4'd1,
        OP_LD_ACC  = 4'd2,
        OP_XCH_ACC = 4'd3,
        OP_ST_PORT = 4'd4,
        OP_LD_LAT  = 4'd5,
        OP_ST_LAT  = 4'd6,
        OP_LD_CNT  = 4'd7,
        OP_ST_CNT  = 4'd8
    } op_e;
endpackage

// File: rtl/dram_ptr.sv
// Pointer register and access-address selection.
// Assumes a synchronous active-low reset. The address is {row, digit}.
module dram_ptr #(
    parameter int AW  = 7,
    parameter int DIG = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_load,
    input  logic          imm_sel,
    input  logic [AW-1:0] imm_addr,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] acc_addr,
    output logic [DIG-1:0] dig_field
);
    // Pointer update from the immediate operand.
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr <= '0;
        else if (ptr_load) ptr <= imm_addr;
    end

    // Access address: the immediate operand or the current pointer.
    always_comb acc_addr = imm_sel ? imm_addr : ptr;

    // Digit field of the pointer, driven continuously.
    always_comb dig_field = ptr[DIG-1:0];
endmodule

// File: rtl/dram_op_decode.sv
// Decodes the operation-select vector into a single operation and builds
// the memory write enable and write data. More than one select set gives
// OP_NONE. Assumes N_OPS matches the operation list in the package.
module dram_op_decode
    import dram_pkg::*;
#(
    parameter int NO = N_OPS,
    parameter int DW = 4
) (
    input  logic [NO-1:0] op_req,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] lat,
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] port_val,
    output op_e           op,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata
);
    localparam int CW = $clog2(NO + 1);

    logic [CW-1:0] n_set;
    logic [3:0]    idx;

    // Count the set selects and find the index of the last one.
    always_comb begin
        n_set = '0;
        idx   = '0;
        for (int i = 0; i < NO; i++) begin
            if (op_req[i]) begin
                n_set = n_set + 1'b1;
                idx   = 4'(i);
            end
        end
    end

    // Only a single select yields an operation.
    always_comb op = (n_set == CW'(1)) ? op_e'(idx + 4'd1) : OP_NONE;

    // Memory write enable and source of the written value.
    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = acc;
        unique case (op)
            OP_ST_ACC, OP_XCH_ACC: begin mem_we = 1'b1; mem_wdata = acc;      end
            OP_ST_PORT:            begin mem_we = 1'b1; mem_wdata = port_val; end
            OP_ST_LAT:             begin mem_we = 1'b1; mem_wdata = lat;      end
            OP_ST_CNT:             begin mem_we = 1'b1; mem_wdata = cnt;      end
            default:               begin mem_we = 1'b0; mem_wdata = acc;      end
        endcase
    end
endmodule

// File: rtl/dram_store.sv
// Storage array of ROWS rows by DIGITS digits with two combinational reads,
// one at the access address and one at the pointer, and one synchronous write.
// Assumes ROWS and DIGITS are powers of two. Contents are not reset.
module dram_store #(
    parameter int ROWS   = 8,
    parameter int DIGITS = 16,
    parameter int DW     = 4,
    parameter int AW     = $clog2(ROWS) + $clog2(DIGITS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DGW = $clog2(DIGITS);

    logic [DW-1:0] mem [ROWS][DIGITS];

    // Write the selected digit of the selected row.
    always_ff @(posedge clk) begin
        if (we) mem[waddr[AW-1:DGW]][waddr[DGW-1:0]] <= wdata;
    end

    // Read ports: access address and pointer address.
    always_comb rdata_a = mem[waddr[AW-1:DGW]][waddr[DGW-1:0]];
    always_comb rdata_b = mem[raddr_b[AW-1:DGW]][raddr_b[DGW-1:0]];
endmodule

// File: rtl/dram_regs.sv
// Accumulator, output latch and counter with their load priorities.
// Memory transfers take precedence over the outside accumulator load and
// over the counter increment. Assumes a synchronous active-low reset.
module dram_regs
    import dram_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_e           op,
    input  logic [DW-1:0] mem_rd,
    input  logic          acc_ld_en,
    input  logic [DW-1:0] acc_ld_val,
    input  logic          cnt_tick,
    output logic [DW-1:0] acc,
    output logic [DW-1:0] lat,
    output logic [DW-1:0] cnt
);
    // Accumulator: memory read or exchange first, then the outside load.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   acc <= '0;
        else if (op == OP_LD_ACC || op == OP_XCH_ACC) acc <= mem_rd;
        else if (acc_ld_en)                           acc <= acc_ld_val;
    end

    // Output latch: loaded only from memory.
    always_ff @(posedge clk) begin
        if (!rst_n)              lat <= '0;
        else if (op == OP_LD_LAT) lat <= mem_rd;
    end

    // Counter: memory load first, otherwise a wrapping increment.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (op == OP_LD_CNT) cnt <= mem_rd;
        else if (cnt_tick)        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/digit_ram_unit.sv
// Top of the digit-addressed scratchpad memory unit. It joins the pointer,
// the operation decoder, the storage array and the transfer registers.
// Assumes that the operation selects come from a sequencer, one per cycle.
module digit_ram_unit
    import dram_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int DIGITS = 16,
    parameter int DW     = 4,
    parameter int NO     = N_OPS,
    localparam int AW    = $clog2(ROWS) + $clog2(DIGITS),
    localparam int DGW   = $clog2(DIGITS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NO-1:0]  op_req,
    input  logic [AW-1:0]  imm_addr,
    input  logic           imm_sel,
    input  logic           ptr_load,
    input  logic [DW-1:0]  port_in,
    input  logic           acc_ld_en,
    input  logic [DW-1:0]  acc_ld_val,
    input  logic           cnt_tick,
    output logic [DW-1:0]  acc_q,
    output logic [DW-1:0]  latch_q,
    output logic [DW-1:0]  cnt_q,
    output logic [AW-1:0]  ptr_q,
    output logic [DGW-1:0] dig_out,
    output logic [DW-1:0]  rd_digit
);
    op_e           op;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rd;
    logic [AW-1:0] acc_addr;

    dram_ptr #(.AW(AW), .DIG(DGW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .imm_sel(imm_sel),
        .imm_addr(imm_addr), .ptr(ptr_q), .acc_addr(acc_addr), .dig_field(dig_out)
    );

    dram_op_decode #(.NO(NO), .DW(DW)) u_dec (
        .op_req(op_req), .acc(acc_q), .lat(latch_q), .cnt(cnt_q),
        .port_val(port_in), .op(op), .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    dram_store #(.ROWS(ROWS), .DIGITS(DIGITS), .DW(DW), .AW(AW)) u_store (
        .clk(clk), .we(mem_we), .waddr(acc_addr), .wdata(mem_wdata),
        .rdata_a(mem_rd), .raddr_b(ptr_q), .rdata_b(rd_digit)
    );

    dram_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .op(op), .mem_rd(mem_rd),
        .acc_ld_en(acc_ld_en), .acc_ld_val(acc_ld_val), .cnt_tick(cnt_tick),
        .acc(acc_q), .lat(latch_q), .cnt(cnt_q)
    );
endmodule

// File: rtl/digit_ram_unit_chk.sv
// Property checker for digit_ram_unit, attached through bind. It observes
// ports only and assumes the operation-select encoding of the brief.
module digit_ram_unit_chk #(
    parameter int NO  = 8,
    parameter int AW  = 7,
    parameter int DW  = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NO-1:0] op_req,
    input logic [AW-1:0] imm_addr,
    input logic          imm_sel,
    input logic          ptr_load,
    input logic [DW-1:0] port_in,
    input logic          acc_ld_en,
    input logic          cnt_tick,
    input logic [DW-1:0] acc_q,
    input logic [DW-1:0] latch_q,
    input logic [DW-1:0] cnt_q,
    input logic [AW-1:0] ptr_q,
    input logic [DW-1:0] rd_digit
);
    // R9: without a pointer load the pointer holds.
    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_load |=> $stable(ptr_q));

    // R10: a pointer load takes the immediate operand.
    p_ptr_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> ptr_q == $past(imm_addr));

    // R3: store accumulator.
    p_st_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req == NO'(1) && !imm_sel && !ptr_load) |=> rd_digit == $past(acc_q));

    // R4: load accumulator.
    p_ld_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req == NO'(2) && !imm_sel) |=> acc_q == $past(rd_digit));

    // R5: exchange in one edge.
    p_xch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req == NO'(4) && !imm_sel && !ptr_load)
        |=> (acc_q == $past(rd_digit) && rd_digit == $past(acc_q)));

    // R6: store input port.
    p_st_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req == NO'(8) && !imm_sel && !ptr_load) |=> rd_digit == $past(port_in));

    // R12: several selects change no register.
    p_multi_noop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(op_req) > 1 && !acc_ld_en && !cnt_tick)
        |=> ($stable(acc_q) && $stable(latch_q) && $stable(cnt_q)));
endmodule

bind digit_ram_unit digit_ram_unit_chk #(.NO(NO), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_req(op_req), .imm_addr(imm_addr),
    .imm_sel(imm_sel), .ptr_load(ptr_load), .port_in(port_in),
    .acc_ld_en(acc_ld_en), .cnt_tick(cnt_tick), .acc_q(acc_q),
    .latch_q(latch_q), .cnt_q(cnt_q), .ptr_q(ptr_q), .rd_digit(rd_digit)
);

// File: tb/digit_ram_unit_tb.sv
`timescale 1ns/1ps
module digit_ram_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_req = '0;
    logic [6:0] imm_addr = '0;
    logic       imm_sel = 1'b0;
    logic       ptr_load = 1'b0;
    logic [3:0] port_in = '0;
    logic       acc_ld_en = 1'b0;
    logic [3:0] acc_ld_val = '0;
    logic       cnt_tick = 1'b0;
    logic [3:0] acc_q, latch_q, cnt_q, dig_out, rd_digit;
    logic [6:0] ptr_q;

    int nvec = 0;
    int nerr = 0;

    logic [3:0] m_mem [128];
    logic [3:0] m_acc, m_lat, m_cnt;
    logic [6:0] m_ptr;

    always #2 clk = ~clk;

    digit_ram_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_req(op_req), .imm_addr(imm_addr),
        .imm_sel(imm_sel), .ptr_load(ptr_load), .port_in(port_in),
        .acc_ld_en(acc_ld_en), .acc_ld_val(acc_ld_val), .cnt_tick(cnt_tick),
        .acc_q(acc_q), .latch_q(latch_q), .cnt_q(cnt_q), .ptr_q(ptr_q),
        .dig_out(dig_out), .rd_digit(rd_digit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [7:0] op);
        if ($countones(op) > 1) return "R12";
        case (op)
            8'h01: return "R3";
            8'h02: return "R4";
            8'h04: return "R5";
            8'h08: return "R6";
            8'h10, 8'h20: return "R7";
            8'h40, 8'h80: return "R8";
            default: return "R13";
        endcase
    endfunction

    // One cycle: drive at the falling edge, update the model, check one edge later.
    task automatic apply(input logic [7:0] op, input logic isel, input logic [6:0] ia,
                         input logic pld, input logic [3:0] pv, input logic ald,
                         input logic [3:0] av, input logic tk);
        logic [6:0] a;
        logic [3:0] rv, nacc, nlat, ncnt;
        string tg;
        op_req = op; imm_sel = isel; imm_addr = ia; ptr_load = pld;
        port_in = pv; acc_ld_en = ald; acc_ld_val = av; cnt_tick = tk;
        a = isel ? ia : m_ptr;
        rv = m_mem[a];
        nacc = ald ? av : m_acc;
        nlat = m_lat;
        ncnt = tk ? m_cnt + 4'd1 : m_cnt;
        if ($countones(op) == 1) begin
            case (op)
                8'h01: m_mem[a] = m_acc;
                8'h02: nacc = rv;
                8'h04: begin m_mem[a] = m_acc; nacc = rv; end
                8'h08: m_mem[a] = pv;
                8'h10: nlat = rv;
                8'h20: m_mem[a] = m_lat;
                8'h40: ncnt = rv;
                8'h80: m_mem[a] = m_cnt;
                default: ;
            endcase
        end
        m_acc = nacc; m_lat = nlat; m_cnt = ncnt;
        if (pld) m_ptr = ia;
        tg = op_tag(op);
        @(posedge clk);
        @(negedge clk);
        chk({tg, " acc"}, acc_q, m_acc);
        chk({tg, " latch"}, latch_q, m_lat);
        chk({tg, " cnt"}, cnt_q, m_cnt);
        chk(isel ? "R9 ptr" : "R10 ptr", ptr_q, m_ptr);
        chk("R11 dig_out", dig_out, m_ptr[3:0]);
        chk({"R2 rd_digit after ", tg}, rd_digit, m_mem[m_ptr]);
    endtask

    initial begin
        #(4 * 150000);
        nerr++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_acc = '0; m_lat = '0; m_cnt = '0; m_ptr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ptr", ptr_q, 7'd0);
        chk("R1 acc", acc_q, 4'd0);
        chk("R1 latch", latch_q, 4'd0);
        chk("R1 cnt", cnt_q, 4'd0);
        rst_n = 1'b1;

        // Fill every location through immediate port writes (R6, R9).
        for (int i = 0; i < 128; i++)
            apply(8'h08, 1'b1, 7'(i), 1'b0, 4'(i * 7 + 3), 1'b0, 4'd0, 1'b0);

        // Directed corners: highest address, exchange, pointer load with access.
        apply(8'h00, 1'b0, 7'h7F, 1'b1, 4'd0, 1'b1, 4'hA, 1'b0);  // R10 R13
        apply(8'h04, 1'b0, 7'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0);  // R5
        apply(8'h01, 1'b0, 7'h00, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0);  // R3 uses old pointer
        apply(8'h02, 1'b0, 7'h00, 1'b0, 4'd0, 1'b1, 4'h6, 1'b0);  // R4 wins over R13
        apply(8'h05, 1'b0, 7'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0);  // R12
        apply(8'hC0, 1'b1, 7'h11, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1);  // R12 with tick
        apply(8'h08, 1'b0, 7'h00, 1'b0, 4'hF, 1'b0, 4'd0, 1'b0);  // R6
        apply(8'h40, 1'b0, 7'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1);  // R8 load beats tick
        apply(8'h00, 1'b0, 7'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b1);  // R8 wrap 15 -> 0
        apply(8'h80, 1'b0, 7'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0);  // R8 store counter
        apply(8'h10, 1'b1, 7'h7F, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0);  // R7 load latch
        apply(8'h20, 1'b0, 7'h00, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0);  // R7 store latch

        // Constrained random traffic.
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] op;
            int r;
            r = int'($urandom % 10);
            if (r == 0)      op = 8'h00;
            else if (r == 1) op = 8'(1 << ($urandom % 8)) | 8'(1 << ($urandom % 8));
            else             op = 8'(1 << ($urandom % 8));
            apply(op, ($urandom % 3) == 0, 7'($urandom), ($urandom % 4) == 0,
                  4'($urandom), ($urandom % 4) == 0, 4'($urandom), ($urandom % 2) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule